// File: doc/BRIEF.md
# Clock Divider and Reset Sequencer

This block takes a fast free-running input clock and an active-low reset request that may change at any time. It makes a half-rate system clock with a 50% duty cycle. It also makes an active-high system reset that changes only on rising edges of that system clock, and a one-period start strobe that tells the processor core it may begin its first instruction fetch.

The reset request passes through a two-stage synchronizer. The block accepts a request only if it stays low for at least five system-clock periods. Once it accepts a request, the system reset stays high for exactly as many periods as the request was held low. The start strobe then fires a fixed six periods after the system reset drops. A request that is too short leaves the chip held in reset, and no start strobe is produced. A new request that arrives while the six-period countdown is running cancels the countdown and puts the reset back at once. The divider keeps running whatever the reset state, so the system clock stays stable while a reset is held.

Top module: `clkrst_seq`

## Requirements
- R1: `sys_clk` toggles on every rising edge of `clk_in`, giving half the input frequency with equal high and low phases, and it keeps toggling while `rst_req_n` is low.
- R2: The request is synchronized by two stages clocked at system-clock edges. If `rst_req_n` is first sampled low at system-clock rising edge k (edges counted from 1), `sys_rst` is high after edge k+2.
- R3: `sys_rst` and `fetch_go` change only at rising edges of `sys_clk`.
- R4: A request sampled low at N consecutive system-clock edges, with N of at least 5, holds `sys_rst` high for exactly N system-clock periods. `sys_rst` then drops after edge N+3.
- R5: A request sampled low at 1 to 4 consecutive edges is too short. `sys_rst` becomes high as in R2 and stays high, and `fetch_go` stays low, until a valid request completes.
- R6: `fetch_go` is high (1 = start fetching) for exactly one system-clock period. It rises at the sixth system-clock rising edge after the edge at which `sys_rst` fell.
- R7: A request that arrives while the fetch countdown is running clears the countdown. `sys_rst` rises with the R2 latency, no `fetch_go` comes from the cancelled countdown, and a later valid request runs the full sequence again.
- R8: From power-up, `sys_rst` is high and `fetch_go` is low. They stay that way, even with `rst_req_n` held high, until a valid request has been seen.
- R9: `fetch_go` is never high while `sys_rst` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Fast free-running input clock |
| rst_req_n | input | 1 | Asynchronous reset request, active low |
| sys_clk | output | 1 | Divided-by-two system clock, 50% duty |
| sys_rst | output | 1 | System reset, active high, aligned to `sys_clk` rising edges |
| fetch_go | output | 1 | One-period strobe allowing the first instruction fetch |

## Verification
The bench drives requests of exactly four and exactly five periods, on either side of the qualification limit. If the comparison were off by one, the four-period pulse would release the system, or the five-period pulse would never release it. Longer pulses check that the reset length tracks the request length. A design that dropped a synchronizer stage, or added one, would move the reset edges by one period. A second request, issued in the middle of the six-period countdown, shows whether the counter is cleared: a design that let the countdown continue would produce a start strobe while reset is asserted. Request edges land at random offsets within the system-clock period, and the system clock is checked cycle by cycle both during a held reset and in normal running.

// File: rtl/clkrst_pkg.sv
// Package: shared types for the clock divider and reset sequencer.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package clkrst_pkg;

    // Sequencer phases: held in reset, counting toward fetch, running.
    typedef enum logic [1:0] {
        SEQ_HOLD = 2'd0,
        SEQ_WAIT = 2'd1,
        SEQ_RUN  = 2'd2
    } seq_state_t;

endpackage

// File: rtl/clkrst_div2.sv
// Module: clkrst_div2
// What:   Divides the input clock by two into a 50% duty system clock and
//         gives an enable that is high in the input cycle whose closing edge
//         is a rising edge of the system clock.
// Assumes: The divider must never stop, so it has no reset. The power-up
//          value comes from the declaration.
module clkrst_div2 (
    input  logic clk_in,
    output logic sys_clk,
    output logic rise_en
);

    logic div_q = 1'b0;

    // Toggle the divider flop on every input edge.
    always_ff @(posedge clk_in) begin
        div_q <= ~div_q;
    end

    assign sys_clk = div_q;
    // The system clock rises at the edge where the divider is currently low.
    assign rise_en = ~div_q;

endmodule

// File: rtl/clkrst_sync.sv
// Module: clkrst_sync
// What:   Multi-stage synchronizer for the asynchronous reset request. It
//         advances only on system-clock rising edges, signalled by en.
// Assumes: STAGES >= 2. Stages power up low, which the block reads as a
//          pending request.
module clkrst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_in,
    input  logic en,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain = '0;

    // Shift the raw request through the stage chain once per system period.
    always_ff @(posedge clk_in) begin
        if (en) begin
            chain <= {chain[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/clkrst_ctrl.sv
// Module: clkrst_ctrl
// What:   Reset sequencer. It counts low samples of the synchronized request,
//         releases the system reset only after a long enough request, and
//         fires the fetch strobe a fixed number of periods after release.
// Assumes: It is clocked at the input rate and steps only when tick is high,
//          so every output moves with a system-clock rising edge. The
//          synchronized request, active low, acts as its synchronous reset.
module clkrst_ctrl
    import clkrst_pkg::*;
#(
    parameter int MIN_LOW_PERIODS = 5,
    parameter int FETCH_DELAY     = 6
) (
    input  logic clk_in,
    input  logic tick,
    input  logic req_s_n,
    input  logic rst_req_n,
    output logic sys_rst,
    output logic fetch_go
);

    localparam int LOW_W = $clog2(MIN_LOW_PERIODS + 1);
    localparam int DLY_W = $clog2(FETCH_DELAY + 1);
    localparam logic [LOW_W-1:0] LOW_LIM = LOW_W'(MIN_LOW_PERIODS);
    localparam logic [DLY_W-1:0] DLY_LIM = DLY_W'(FETCH_DELAY);

    seq_state_t       state   = SEQ_HOLD;
    logic [LOW_W-1:0] low_cnt = '0;
    logic [DLY_W-1:0] dly_cnt = '0;
    logic             rst_q   = 1'b1;
    logic             go_q    = 1'b0;

    // Step the qualify / release / countdown sequence once per system period.
    always_ff @(posedge clk_in) begin
        if (tick) begin
            go_q <= 1'b0;
            if (!req_s_n) begin
                state   <= SEQ_HOLD;
                rst_q   <= 1'b1;
                dly_cnt <= '0;
                if (low_cnt != LOW_LIM) begin
                    low_cnt <= low_cnt + 1'b1;
                end
            end else begin
                case (state)
                    SEQ_HOLD: begin
                        low_cnt <= '0;
                        if (low_cnt == LOW_LIM) begin
                            state   <= SEQ_WAIT;
                            rst_q   <= 1'b0;
                            dly_cnt <= DLY_W'(1);
                        end
                    end
                    SEQ_WAIT: begin
                        if (dly_cnt == DLY_LIM) begin
                            go_q  <= 1'b1;
                            state <= SEQ_RUN;
                        end else begin
                            dly_cnt <= dly_cnt + 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign sys_rst  = rst_q;
    assign fetch_go = go_q;

    // R3
    rst_edge_only_chk: assert property (@(posedge clk_in) disable iff (!rst_req_n)
        !tick |=> ($stable(sys_rst) && $stable(fetch_go)));

    // R7
    req_forces_rst_chk: assert property (@(posedge clk_in) disable iff (!rst_req_n)
        (tick && !req_s_n) |=> sys_rst);

    // R5
    short_req_holds_chk: assert property (@(posedge clk_in) disable iff (!rst_req_n)
        (tick && req_s_n && state == SEQ_HOLD && low_cnt != LOW_LIM) |=> sys_rst);

    // R9
    go_excl_rst_chk: assert property (@(posedge clk_in) disable iff (!rst_req_n)
        fetch_go |-> !sys_rst);

    // R6
    go_one_period_chk: assert property (@(posedge clk_in) disable iff (!rst_req_n)
        (tick && fetch_go) |=> !fetch_go);

endmodule

// File: rtl/clkrst_seq.sv
// Module: clkrst_seq (top)
// What:   Ties the divide-by-two clock, the request synchronizer and the reset
//         sequencer together.
// Assumes: clk_in runs freely from power-up. rst_req_n may change at any time.
module clkrst_seq #(
    parameter int SYNC_STAGES     = 2,
    parameter int MIN_LOW_PERIODS = 5,
    parameter int FETCH_DELAY     = 6
) (
    input  logic clk_in,
    input  logic rst_req_n,
    output logic sys_clk,
    output logic sys_rst,
    output logic fetch_go
);

    logic tick;
    logic req_s_n;

    clkrst_div2 u_div (
        .clk_in  (clk_in),
        .sys_clk (sys_clk),
        .rise_en (tick)
    );

    clkrst_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_in  (clk_in),
        .en      (tick),
        .d_async (rst_req_n),
        .q_sync  (req_s_n)
    );

    clkrst_ctrl #(
        .MIN_LOW_PERIODS (MIN_LOW_PERIODS),
        .FETCH_DELAY     (FETCH_DELAY)
    ) u_ctrl (
        .clk_in    (clk_in),
        .tick      (tick),
        .req_s_n   (req_s_n),
        .rst_req_n (rst_req_n),
        .sys_rst   (sys_rst),
        .fetch_go  (fetch_go)
    );

    // R1
    div_phase_chk: assert property (@(posedge clk_in) disable iff (!rst_req_n)
        tick |=> sys_clk);

endmodule

// File: tb/clkrst_seq_bench.sv
// Directed bench for clkrst_seq. Each task runs one scenario and checks it.
module clkrst_seq_bench;

    logic clk_in = 1'b0;
    logic rst_req_n = 1'b1;
    logic sys_clk;
    logic sys_rst;
    logic fetch_go;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;
    logic exp_rst = 1'b1;

    clkrst_seq u_clkrst_seq (
        .clk_in    (clk_in),
        .rst_req_n (rst_req_n),
        .sys_clk   (sys_clk),
        .sys_rst   (sys_rst),
        .fetch_go  (fetch_go)
    );

    // 50 MHz input clock.
    always #10 clk_in = ~clk_in;

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    // Advance to just after the next system-clock rising edge.
    task automatic step();
        @(posedge sys_clk);
        #1;
    endtask

    // Wait a random time within the period, well before the next sampling edge.
    task automatic jitter();
        #($urandom_range(0, 30));
    endtask

    // R8: power-up state, with the request left high.
    task automatic t_powerup();
        for (int k = 1; k <= 20; k++) begin
            step();
            check("R8 sys_rst", sys_rst, 1'b1);
            check("R8 fetch_go", fetch_go, 1'b0);
        end
        exp_rst = 1'b1;
    endtask

    // R1: the system clock alternates on every input edge.
    task automatic t_clock(input bit hold_low);
        logic prev;
        if (hold_low) rst_req_n = 1'b0;
        @(posedge clk_in); #1;
        prev = sys_clk;
        for (int k = 0; k < 12; k++) begin
            @(posedge clk_in); #1;
            check("R1 sys_clk toggle", sys_clk, ~prev);
            prev = sys_clk;
        end
        if (hold_low) begin
            // Leave a long valid request and run it out.
            step();
            rst_req_n = 1'b1;
            for (int k = 0; k < 16; k++) step();
            exp_rst = 1'b0;
        end
    endtask

    // R2 R4 R5 R6: one request of n periods.
    task automatic t_pulse(input int n);
        bit   valid = (n >= 5);
        logic er;
        logic eg;
        step();
        jitter();
        rst_req_n = 1'b0;
        for (int k = 1; k <= n + 12; k++) begin
            step();
            if (k < 3)       er = exp_rst;
            else if (!valid) er = 1'b1;
            else             er = (k <= n + 2);
            eg = valid && (k == n + 9);
            if (valid) begin
                check("R4 sys_rst length", sys_rst, er);
                check("R6 fetch_go timing", fetch_go, eg);
            end else begin
                check("R5 short request sys_rst", sys_rst, er);
                check("R5 short request fetch_go", fetch_go, eg);
            end
            if (k == 3) check("R2 sync latency", sys_rst, 1'b1);
            if (k == n) begin
                jitter();
                rst_req_n = 1'b1;
            end
        end
        exp_rst = valid ? 1'b0 : 1'b1;
    endtask

    // R7: a second request during the fetch countdown.
    task automatic t_retrigger();
        logic er;
        step();
        jitter();
        rst_req_n = 1'b0;
        for (int k = 1; k <= 30; k++) begin
            step();
            if (k < 3)       er = exp_rst;
            else if (k <= 8) er = 1'b1;
            else if (k <= 13) er = 1'b0;
            else if (k <= 19) er = 1'b1;
            else             er = 1'b0;
            check("R7 sys_rst", sys_rst, er);
            check("R7 fetch_go", fetch_go, (k == 26));
            if (k == 6 || k == 17) begin
                jitter();
                rst_req_n = 1'b1;
            end
            if (k == 11) begin
                jitter();
                rst_req_n = 1'b0;
            end
        end
        exp_rst = 1'b0;
    endtask

    initial begin
        t_powerup();
        t_clock(1'b0);
        t_pulse(5);
        t_pulse(9);
        t_pulse(4);
        t_pulse(2);
        t_pulse(5);
        t_retrigger();
        t_clock(1'b1);
        t_clock(1'b0);
        t_pulse(7);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    initial begin
        repeat (50000) @(posedge clk_in);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule